// File: doc/BRIEF.md
# Posit Bit-Level Operation Unit

This block evaluates a set of posit operations directly on the encoded words, without splitting them into sign, regime, exponent and fraction fields. Two's-complement integers and posit words share one ordering, so the unit costs about as much as a small integer ALU. Each operation is an adder, an inverter or a shift applied to the whole word. A 4-bit opcode selects one of nine operations: negation, absolute value, four ordered comparisons, reciprocal, one-minus-x, and a fast pseudo-sigmoid. Every result is registered, so the outputs follow the inputs of the previous clock edge.

Two operations give exact results only for a posit type with no exponent bits: one-minus-x and the pseudo-sigmoid. A generate switch on the `ES` parameter decides whether their datapath is built. When `ES` is not zero, both opcodes raise the illegal-operation flag. The not-a-real pattern is the sign bit alone, written NaR below. The unit handles NaR explicitly: a comparison involving NaR is false and sets an exception flag. In the text below, ONE is the 1.0 code: only bit N-2 set.

Top module: `posit_bitop_unit`

## Requirements
- R1: While `rst_n` is low, all four outputs are zero.
- R2: Opcode 0 (negate) returns the two's complement of `opnd_a` modulo 2^N. Zero gives zero, and NaR (only bit N-1 set) gives NaR.
- R3: Opcode 1 (absolute value) returns the two's complement of `opnd_a` when bit N-1 is set, and `opnd_a` unchanged otherwise.
- R4: Opcodes 2, 3, 4 and 5 compute a<b, a<=b, a>b and a>=b, treating both words as signed two's-complement integers. The truth value goes to `cmp_q`, and `result_q` is zero.
- R5: A comparison opcode with NaR on either operand gives `cmp_q`=0 and `nar_exc_q`=1.
- R6: Opcode 6 (reciprocal) inverts bits N-2..0 of `opnd_a` and then adds 1 to the whole word. Zero gives NaR, and NaR gives NaR.
- R7: Opcode 7 (one-minus-x) with ES=0 and `opnd_a` in [0, ONE], compared as signed values, returns ONE minus `opnd_a` modulo 2^N.
- R8: Opcode 7 with ES=0 and `opnd_a` outside [0, ONE] sets `illegal_q`=1 and gives `result_q`=NaR.
- R9: Opcode 8 (pseudo-sigmoid) with ES=0 flips bit N-1 of `opnd_a` and then shifts the word right logically by 2.
- R10: When ES is not 0, opcodes 7 and 8 set `illegal_q` and give NaR for every operand.
- R11: Opcodes 9 to 15 set `illegal_q`, give NaR on `result_q` and give `cmp_q`=0.
- R12: The outputs take their values one clock edge after the inputs are sampled. `illegal_q` and `nar_exc_q` are never both set. Non-comparison opcodes give `cmp_q`=0 and `nar_exc_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation select |
| opnd_a | input | N | First posit operand |
| opnd_b | input | N | Second posit operand (comparisons only) |
| result_q | output | N | Registered posit result |
| cmp_q | output | 1 | Registered comparison truth value |
| illegal_q | output | 1 | Registered illegal-operation flag |
| nar_exc_q | output | 1 | Registered NaR comparison exception |

## Verification
Properties checked on every cycle:
- Negation sums to zero with its operand.
- Absolute value never has its sign bit set unless the operand is NaR.
- Comparisons against NaR are false and flagged, and the reciprocal of NaR is NaR.
- An illegal result is always NaR with `cmp_q` low, and the two flags never overlap.
- The pseudo-sigmoid always clears its top two bits.

Only the bench's scenarios show the exact values: the comparison truth tables, reciprocal codes, one-minus-x inside and at the edges of [0, ONE], and the opcode guarding of a second instance built with ES=1.

// File: rtl/posit_bitop_pkg.sv
package posit_bitop_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      PB_NEG   = 4'd0,
      PB_ABS   = 4'd1,
      PB_LT    = 4'd2,
      PB_LE    = 4'd3,
      PB_GT    = 4'd4,
      PB_GE    = 4'd5,
      PB_RECIP = 4'd6,
      PB_ONEM  = 4'd7,
      PB_SIGM  = 4'd8
   } pb_op_e;

   function automatic logic is_cmp_op(input logic [OP_W-1:0] op);
      return (op >= 4'(PB_LT)) && (op <= 4'(PB_GE));
   endfunction

endpackage

// File: rtl/posit_unary_ops.sv
module posit_unary_ops #(
   parameter int N = 8
) (
   input  logic [N-1:0] a,
   output logic [N-1:0] neg_o,
   output logic [N-1:0] abs_o,
   output logic [N-1:0] rcp_o
);
   localparam logic [N-1:0] NAR_W  = {1'b1, {(N-1){1'b0}}};
   localparam logic [N-1:0] BODY_M = {1'b0, {(N-1){1'b1}}};

   logic [N-1:0] twos;
   logic [N-1:0] flip_body;

   // Two's complement also maps zero and NaR onto themselves.
   assign twos  = (~a) + {{(N-1){1'b0}}, 1'b1};
   assign neg_o = twos;
   assign abs_o = a[N-1] ? twos : a;

   // Invert all but the sign, then increment the whole word.
   assign flip_body = a ^ BODY_M;
   always_comb begin
      if (a == NAR_W) rcp_o = NAR_W;
      else            rcp_o = flip_body + {{(N-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/posit_cmp_ops.sv
module posit_cmp_ops
   import posit_bitop_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [OP_W-1:0] op,
   input  logic [N-1:0]    a,
   input  logic [N-1:0]    b,
   output logic            cmp_o,
   output logic            nar_o
);
   localparam logic [N-1:0] NAR_W = {1'b1, {(N-1){1'b0}}};

   logic lt, eq, nar_any;

   assign lt      = $signed(a) < $signed(b);
   assign eq      = (a == b);
   assign nar_any = (a == NAR_W) || (b == NAR_W);

   always_comb begin
      cmp_o = 1'b0;
      unique case (op)
         4'(PB_LT): cmp_o = lt;
         4'(PB_LE): cmp_o = lt | eq;
         4'(PB_GT): cmp_o = ~(lt | eq);
         4'(PB_GE): cmp_o = ~lt;
         default:   cmp_o = 1'b0;
      endcase
      if (nar_any) cmp_o = 1'b0;
   end

   assign nar_o = is_cmp_op(op) && nar_any;
endmodule

// File: rtl/posit_es0_ops.sv
module posit_es0_ops #(
   parameter int N  = 8,
   parameter int ES = 0
) (
   input  logic [N-1:0] a,
   output logic [N-1:0] onem_o,
   output logic         onem_ok,
   output logic [N-1:0] sig_o,
   output logic         sig_ok
);
   localparam logic [N-1:0] ONE_W = {2'b01, {(N-2){1'b0}}};
   localparam logic [N-1:0] MSB_W = {1'b1, {(N-1){1'b0}}};

   generate
      if (ES == 0) begin : g_exact
         logic in_unit;
         assign in_unit = !a[N-1] && (a <= ONE_W);
         assign onem_o  = ONE_W + ((~a) + {{(N-1){1'b0}}, 1'b1});
         assign onem_ok = in_unit;
         assign sig_o   = (a ^ MSB_W) >> 2;
         assign sig_ok  = 1'b1;
      end else begin : g_guarded
         assign onem_o  = a & {N{1'b0}};
         assign onem_ok = 1'b0;
         assign sig_o   = {N{1'b0}};
         assign sig_ok  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/posit_bitop_unit.sv
module posit_bitop_unit
   import posit_bitop_pkg::*;
#(
   parameter int N  = 8,
   parameter int ES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    op_code,
   input  logic [N-1:0]  opnd_a,
   input  logic [N-1:0]  opnd_b,
   output logic [N-1:0]  result_q,
   output logic          cmp_q,
   output logic          illegal_q,
   output logic          nar_exc_q
);
   localparam logic [N-1:0] NAR_W = {1'b1, {(N-1){1'b0}}};

   generate
      if (N < 4) begin : g_bad_n
         $error("posit_bitop_unit: N must be at least 4");
      end
      if (ES < 0 || ES > N - 3) begin : g_bad_es
         $error("posit_bitop_unit: ES out of range for N");
      end
   endgenerate

   logic [N-1:0] neg_w, abs_w, rcp_w, onem_w, sig_w;
   logic         onem_ok, sig_ok, cmp_w, nar_w;
   logic [N-1:0] res_d;
   logic         ill_d;

   posit_unary_ops #(.N(N)) u_unary (
      .a(opnd_a), .neg_o(neg_w), .abs_o(abs_w), .rcp_o(rcp_w)
   );

   posit_cmp_ops #(.N(N)) u_cmp (
      .op(op_code), .a(opnd_a), .b(opnd_b), .cmp_o(cmp_w), .nar_o(nar_w)
   );

   posit_es0_ops #(.N(N), .ES(ES)) u_es0 (
      .a(opnd_a), .onem_o(onem_w), .onem_ok(onem_ok),
      .sig_o(sig_w), .sig_ok(sig_ok)
   );

   always_comb begin
      res_d = {N{1'b0}};
      ill_d = 1'b0;
      case (op_code)
         4'(PB_NEG):   res_d = neg_w;
         4'(PB_ABS):   res_d = abs_w;
         4'(PB_LT), 4'(PB_LE), 4'(PB_GT), 4'(PB_GE):
                       res_d = {N{1'b0}};
         4'(PB_RECIP): res_d = rcp_w;
         4'(PB_ONEM):  begin
                          ill_d = !onem_ok;
                          res_d = onem_ok ? onem_w : NAR_W;
                       end
         4'(PB_SIGM):  begin
                          ill_d = !sig_ok;
                          res_d = sig_ok ? sig_w : NAR_W;
                       end
         default:      begin
                          ill_d = 1'b1;
                          res_d = NAR_W;
                       end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q  <= {N{1'b0}};
         cmp_q     <= 1'b0;
         illegal_q <= 1'b0;
         nar_exc_q <= 1'b0;
      end else begin
         result_q  <= res_d;
         cmp_q     <= cmp_w;
         illegal_q <= ill_d;
         nar_exc_q <= nar_w;
      end
   end
endmodule

// File: rtl/posit_bitop_chk.sv
module posit_bitop_chk #(
   parameter int N  = 8,
   parameter int ES = 0
) (
   input logic         clk,
   input logic         rst_n,
   input logic [3:0]   op_code,
   input logic [N-1:0] opnd_a,
   input logic [N-1:0] opnd_b,
   input logic [N-1:0] result_q,
   input logic         cmp_q,
   input logic         illegal_q,
   input logic         nar_exc_q
);
   localparam logic [N-1:0] NAR_W = {1'b1, {(N-1){1'b0}}};

   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   AST_NEG_SUMS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(op_code) == 4'd0 |-> (result_q + $past(opnd_a)) == {N{1'b0}}) // R2
      else $error("negate mismatch");

   AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(op_code) == 4'd1 && $past(opnd_a) != NAR_W |-> !result_q[N-1]) // R3
      else $error("abs negative");

   AST_CMP_NAR_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(op_code) >= 4'd2 && $past(op_code) <= 4'd5 &&
      ($past(opnd_a) == NAR_W || $past(opnd_b) == NAR_W) |-> !cmp_q && nar_exc_q) // R5
      else $error("NaR compare");

   AST_RECIP_NAR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(op_code) == 4'd6 && $past(opnd_a) == NAR_W |-> result_q == NAR_W) // R6
      else $error("recip NaR");

   AST_SIGMOID_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      live && ES == 0 && $past(op_code) == 4'd8 |-> result_q[N-1:N-2] == 2'b00) // R9
      else $error("sigmoid range");

   AST_GUARDED_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      live && ES != 0 && ($past(op_code) == 4'd7 || $past(op_code) == 4'd8) |-> illegal_q) // R10
      else $error("guard");

   AST_ILLEGAL_GIVES_NAR: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_q |-> result_q == NAR_W && !cmp_q) // R11
      else $error("illegal result");

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(illegal_q && nar_exc_q)) // R12
      else $error("flags overlap");
endmodule

bind posit_bitop_unit posit_bitop_chk #(.N(N), .ES(ES)) chk_i (
   .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
   .opnd_b(opnd_b), .result_q(result_q), .cmp_q(cmp_q),
   .illegal_q(illegal_q), .nar_exc_q(nar_exc_q)
);

// File: tb/posit_bitop_unit_tb_top.sv
module posit_bitop_unit_tb_top;
   localparam int N = 8;
   localparam logic [N-1:0] NAR = 8'h80;
   localparam logic [N-1:0] ONE = 8'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] op = 4'd0;
   logic [N-1:0] a = '0, b = '0;
   logic [N-1:0] res0, res1;
   logic cmp0, cmp1, ill0, ill1, exc0, exc1;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   posit_bitop_unit #(.N(N), .ES(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_code(op), .opnd_a(a), .opnd_b(b),
      .result_q(res0), .cmp_q(cmp0), .illegal_q(ill0), .nar_exc_q(exc0));

   posit_bitop_unit #(.N(N), .ES(1)) dut_g (
      .clk(clk), .rst_n(rst_n), .op_code(op), .opnd_a(a), .opnd_b(b),
      .result_q(res1), .cmp_q(cmp1), .illegal_q(ill1), .nar_exc_q(exc1));

   // Packed as {illegal, exc, cmp, result}
   function automatic logic [N+2:0] model(input logic [3:0] o, input logic [N-1:0] x,
                                          input logic [N-1:0] y, input int es);
      logic [N-1:0] r = '0;
      logic c = 1'b0, il = 1'b0, ex = 1'b0;
      case (o)
         4'd0: r = -x;
         4'd1: r = x[N-1] ? -x : x;
         4'd2, 4'd3, 4'd4, 4'd5: begin
            if (x == NAR || y == NAR) ex = 1'b1;
            else case (o)
               4'd2: c = $signed(x) <  $signed(y);
               4'd3: c = $signed(x) <= $signed(y);
               4'd4: c = $signed(x) >  $signed(y);
               default: c = $signed(x) >= $signed(y);
            endcase
         end
         4'd6: r = (x == NAR) ? NAR : ((x ^ 8'h7F) + 8'd1);
         4'd7: begin
            if (es == 0 && $signed(x) >= 0 && x <= ONE) r = ONE - x;
            else begin il = 1'b1; r = NAR; end
         end
         4'd8: begin
            if (es == 0) r = (x ^ NAR) >> 2;
            else begin il = 1'b1; r = NAR; end
         end
         default: begin il = 1'b1; r = NAR; end
      endcase
      return {il, ex, c, r};
   endfunction

   task automatic check(input string req, input logic [N+2:0] got, input logic [N+2:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s op=%0d a=%h b=%h got=%h expected=%h", req, op, a, b, got, exp);
      end
   endtask

   function automatic string req_of(input logic [3:0] o, input logic [N-1:0] x, input logic [N-1:0] y);
      if (o == 4'd0) return "R2";
      if (o == 4'd1) return "R3";
      if (o >= 4'd2 && o <= 4'd5) return (x == NAR || y == NAR) ? "R5" : "R4";
      if (o == 4'd6) return "R6";
      if (o == 4'd7) return ($signed(x) >= 0 && x <= ONE) ? "R7" : "R8";
      if (o == 4'd8) return "R9";
      return "R11";
   endfunction

   // Drive after a falling edge, sample at the next falling edge (one register)
   task automatic apply(input logic [3:0] o, input logic [N-1:0] x, input logic [N-1:0] y);
      op = o; a = x; b = y;
      @(negedge clk);
      check(req_of(o, x, y), {ill0, exc0, cmp0, res0}, model(o, x, y, 0));
      check((o == 4'd7 || o == 4'd8) ? "R10" : "R12", {ill1, exc1, cmp1, res1}, model(o, x, y, 1));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed_dummy;
      seed_dummy = $urandom(32'h5EED_0042);
      op = 4'd6; a = 8'h00;
      repeat (3) @(negedge clk);
      check("R1", {ill0, exc0, cmp0, res0}, '0);
      check("R1", {ill1, exc1, cmp1, res1}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      apply(4'd0, 8'h00, 8'h00);
      apply(4'd0, NAR, 8'h00);
      apply(4'd0, ONE, 8'h00);
      apply(4'd1, 8'hC0, 8'h00);
      apply(4'd1, 8'h20, 8'h00);
      apply(4'd2, 8'hF0, 8'h10);
      apply(4'd3, 8'h33, 8'h33);
      apply(4'd4, 8'h33, 8'h33);
      apply(4'd5, 8'h81, 8'h7F);
      apply(4'd2, NAR, 8'h10);
      apply(4'd5, 8'h10, NAR);
      apply(4'd6, 8'h00, 8'h00);
      apply(4'd6, NAR, 8'h00);
      apply(4'd6, 8'h60, 8'h00);
      apply(4'd6, 8'hC0, 8'h00);
      apply(4'd7, 8'h00, 8'h00);
      apply(4'd7, ONE, 8'h00);
      apply(4'd7, 8'h20, 8'h00);
      apply(4'd7, 8'h41, 8'h00);
      apply(4'd7, 8'hE0, 8'h00);
      apply(4'd8, 8'h00, 8'h00);
      apply(4'd8, 8'hFF, 8'h00);
      apply(4'd8, NAR, 8'h00);
      for (int k = 9; k < 16; k++) apply(4'(k), 8'h5A, 8'hA5);
      // constrained random with biased specials
      for (int i = 0; i < 2000; i++) begin
         logic [3:0] ro;
         logic [N-1:0] ra, rb;
         ro = 4'($urandom_range(0, 9));
         ra = ($urandom_range(0, 7) == 0) ? NAR : 8'($urandom);
         rb = ($urandom_range(0, 7) == 0) ? NAR : 8'($urandom);
         if (ro == 4'd7 && $urandom_range(0, 1) == 1) ra = 8'($urandom_range(0, 64));
         if ($urandom_range(0, 9) == 0) rb = ra;
         apply(ro, ra, rb);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule